// File: doc/BRIEF.md
# ADC Offset Compensation Calibrator

This block measures the offset error of a 10-bit converter and keeps a signed correction for it. A start pulse begins a calibration run. The block takes a snapshot of the engine control word. It then drives a calibration control word that forces the converter input to half of the reference and enables only channel 0. After a programmable settling delay, it requests sixteen samples. Before each request it waits a full programmable sample period, so every sample is fresh. The sixteen samples are summed, the sum is divided by sixteen with a right shift, and the compensation value is stored as midscale (512) minus that mean. When the run ends, the snapshot of the control word is restored.

Outside a run, a combinational read path applies the stored compensation to raw conversion results. On channel 7 with battery sensing enabled, both the raw value and the offset are scaled by a battery gain before they are added. The gain is 3/1 when bit 6 of the control word is set and 3/2 when it is clear.

Top module: `adc_offset_cal`

## Requirements
- R1: After synchronous active-low reset, `busy`, `done` and `smp_req` are 0 and `comp_value` is 0.
- R2: A `start` pulse while idle raises `busy` on the next cycle. While `busy`, `ctrl_out` equals the control word captured at start with these changes: bit 0 set, bits 3:1 set to 3'b111, bit 4 (force-to-midscale) set, and bits 31:16 set to 16'h0001 so that only channel 0 is enabled. All other bits are preserved.
- R3: The first `smp_req` is seen `settle_cycles + period_cycles + 3` cycles after the cycle in which `start` was high.
- R4: Once `smp_req` rises, it stays high until `smp_ack` is sampled. The next request appears `period_cycles + 2` cycles after the cycle in which the ack was given.
- R5: A run accepts exactly 16 samples. `done` is not raised before the sixteenth ack.
- R6: On the cycle after the sixteenth ack, `done` is high for exactly one cycle and `busy` is low. On that same cycle `comp_value` becomes the 11-bit signed value 512 − (sum of the 16 samples >> 4). `comp_value` changes on no other cycle.
- R7: On the `done` cycle, `ctrl_out` equals the control word captured at start, even if `ctrl_in` changed during the run.
- R8: A `start` pulse while `busy` is ignored: the run still takes exactly 16 samples and ends with one `done`, and no new run follows.
- R9: Outside battery mode, `rd_offset` equals `comp_value` and `rd_corr` equals `rd_raw + comp_value`.
- R10: When `bat_en` is 1 and `rd_ch` is 7, both the raw value and the offset are multiplied by 3. When `ctrl_in` bit 6 is clear, each product is then halved with truncation toward zero. `rd_corr` is the sum of the two scaled terms, and `rd_offset` is the scaled offset.
- R11: The accumulator does not overflow. Sixteen samples of 1023 give −511, sixteen samples of 0 give 512, and sixteen samples of 512 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration run (used only when idle) |
| settle_cycles | input | 20 | Settling delay count |
| period_cycles | input | 20 | Sample period count |
| ctrl_in | input | 32 | Engine control word in normal use |
| ctrl_out | output | 32 | Control word driven to the converter |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| smp_req | output | 1 | Sample request to the converter |
| smp_ack | input | 1 | Sample valid from the converter |
| smp_data | input | 10 | Channel 0 sample value |
| comp_value | output | 11 | Signed compensation value |
| bat_en | input | 1 | Battery sensing enabled |
| rd_ch | input | 4 | Channel of the raw read |
| rd_raw | input | 10 | Raw conversion result |
| rd_offset | output | 14 | Offset applied to this channel (signed) |
| rd_corr | output | 14 | Corrected result (signed) |

## Verification
The hardest case to reach from the ports is a start pulse arriving in the middle of a run while the converter holds off its ack. The bench drives start together with the sixth ack and delays each ack by a random number of cycles. It then confirms that the sample count, the single done pulse and the stored value are unaffected. Exact request timing after the settling delay and between samples is measured cycle by cycle. Extreme sample sets (all zero, all full scale, all midscale) exercise the limits of the accumulator and the signed result.

// File: rtl/adc_cal_pkg.sv
// Shared definitions for the offset calibrator: sequencer states and
// control-word bit positions that the converter decodes.
package adc_cal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_GAP    = 2'd2,
        ST_REQ    = 2'd3
    } cal_state_t;

    localparam int CTL_EN_BIT   = 0;
    localparam int CTL_MODE_LO  = 1;
    localparam int CTL_MODE_HI  = 3;
    localparam int CTL_SENSE_BIT = 4;
    localparam int CTL_DIV_BIT  = 6;
    localparam logic [2:0] MODE_RUN = 3'b111;
endpackage

// File: rtl/cal_countdown.sv
// Loadable down counter. Assumes load has priority; holds at zero.
module cal_countdown #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Count down from the loaded value and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cal_accum.sv
// Sums 2**AVG_LOG2 samples and forms midscale minus the mean.
// Assumes clear and add are never high together.
module cal_accum #(
    parameter int RES_W    = 10,
    parameter int AVG_LOG2 = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    add,
    input  logic [RES_W-1:0]        sample,
    output logic                    last,
    output logic signed [RES_W:0]   comp_next
);
    localparam int ACC_W = RES_W + AVG_LOG2;
    localparam logic [AVG_LOG2-1:0] LAST_IDX = {AVG_LOG2{1'b1}};
    localparam logic signed [RES_W:0] MID = (RES_W+1)'(1 << (RES_W - 1));

    logic [ACC_W-1:0]    acc_q;
    logic [AVG_LOG2-1:0] idx_q;
    logic [ACC_W-1:0]    acc_sum;
    logic [RES_W-1:0]    mean;

    // Keep the running sum and the index of the next sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
            idx_q <= '0;
        end else if (add) begin
            acc_q <= acc_sum;
            idx_q <= idx_q + 1'b1;
        end
    end

    // Sum including the sample being accepted, its mean, and the result.
    always_comb begin
        acc_sum   = acc_q + ACC_W'(sample);
        mean      = acc_sum[ACC_W-1:AVG_LOG2];
        comp_next = MID - $signed({1'b0, mean});
    end

    assign last = add && (idx_q == LAST_IDX);
endmodule

// File: rtl/cal_gain.sv
// Optional 3/1 or 3/2 gain, with halving that truncates toward zero.
// Assumes OUT_W is at least IN_W + 2.
module cal_gain #(
    parameter int IN_W  = 11,
    parameter int OUT_W = 14
) (
    input  logic signed [IN_W-1:0]  x,
    input  logic                    en,
    input  logic                    full,
    output logic signed [OUT_W-1:0] y
);
    logic signed [OUT_W-1:0] ext, prod, bias, half;

    // Triple the input, then halve it toward zero when the divider is clear.
    always_comb begin
        ext  = OUT_W'(x);
        prod = (ext <<< 1) + ext;
        bias = {{(OUT_W-1){1'b0}}, prod[OUT_W-1]};
        half = (prod + bias) >>> 1;
        if (!en)
            y = ext;
        else if (full)
            y = prod;
        else
            y = half;
    end
endmodule

// File: rtl/adc_offset_cal.sv
// Offset compensation calibrator: forces midscale, settles, averages
// 2**AVG_LOG2 fresh channel-0 samples, stores midscale minus mean, restores
// the control word. Also provides a combinational corrected-read path.
// Assumes CTRL_W - NUM_CH is the bit where the channel-enable field starts.
module adc_offset_cal #(
    parameter int RES_W    = 10,
    parameter int AVG_LOG2 = 4,
    parameter int TIMER_W  = 20,
    parameter int CTRL_W   = 32,
    parameter int NUM_CH   = 16,
    parameter int BAT_CH   = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [TIMER_W-1:0]          settle_cycles,
    input  logic [TIMER_W-1:0]          period_cycles,
    input  logic [CTRL_W-1:0]           ctrl_in,
    output logic [CTRL_W-1:0]           ctrl_out,
    output logic                        busy,
    output logic                        done,
    output logic                        smp_req,
    input  logic                        smp_ack,
    input  logic [RES_W-1:0]            smp_data,
    output logic signed [RES_W:0]       comp_value,
    input  logic                        bat_en,
    input  logic [$clog2(NUM_CH)-1:0]   rd_ch,
    input  logic [RES_W-1:0]            rd_raw,
    output logic signed [RES_W+3:0]     rd_offset,
    output logic signed [RES_W+3:0]     rd_corr
);
    import adc_cal_pkg::*;

    localparam int COMP_W = RES_W + 1;
    localparam int CORR_W = RES_W + 4;
    localparam int CH_W   = $clog2(NUM_CH);
    localparam int CH_LO  = CTRL_W - NUM_CH;

    cal_state_t          state_q;
    logic [CTRL_W-1:0]   snap_q, ctrl_q, cal_word;
    logic signed [COMP_W-1:0] comp_q, comp_next;
    logic                done_q;
    logic                t_load, t_zero, acc_clear, acc_add, acc_last;
    logic [TIMER_W-1:0]  t_val;

    // Calibration control word derived from the live control word.
    always_comb begin
        cal_word = ctrl_in;
        cal_word[CTL_EN_BIT] = 1'b1;
        cal_word[CTL_MODE_HI:CTL_MODE_LO] = MODE_RUN;
        cal_word[CTL_SENSE_BIT] = 1'b1;
        cal_word[CTRL_W-1:CH_LO] = {{(NUM_CH-1){1'b0}}, 1'b1};
    end

    // Timer and accumulator control decoded from the sequencer state.
    always_comb begin
        acc_clear = (state_q == ST_IDLE) && start;
        acc_add   = (state_q == ST_REQ) && smp_ack;
        t_load    = acc_clear
                 || ((state_q == ST_SETTLE) && t_zero)
                 || (acc_add && !acc_last);
        t_val     = (state_q == ST_IDLE) ? settle_cycles : period_cycles;
    end

    cal_countdown #(.W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_zero)
    );

    cal_accum #(.RES_W(RES_W), .AVG_LOG2(AVG_LOG2)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (acc_clear),
        .add       (acc_add),
        .sample    (smp_data),
        .last      (acc_last),
        .comp_next (comp_next)
    );

    // Sequencer: settle, then alternate sample-period wait and request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            snap_q  <= '0;
            ctrl_q  <= '0;
            comp_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    ctrl_q <= ctrl_in;
                    if (start) begin
                        snap_q  <= ctrl_in;
                        ctrl_q  <= cal_word;
                        state_q <= ST_SETTLE;
                    end
                end
                ST_SETTLE: if (t_zero) state_q <= ST_GAP;
                ST_GAP:    if (t_zero) state_q <= ST_REQ;
                ST_REQ: begin
                    if (smp_ack) begin
                        if (acc_last) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                            comp_q  <= comp_next;
                            ctrl_q  <= snap_q;
                        end else begin
                            state_q <= ST_GAP;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ctrl_out   = ctrl_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = done_q;
    assign smp_req    = (state_q == ST_REQ);
    assign comp_value = comp_q;

    // Corrected-read path: gain stage 0 scales the raw value, stage 1 the offset.
    logic signed [COMP_W-1:0] g_in  [2];
    logic signed [CORR_W-1:0] g_out [2];
    logic                     bat_sel;

    assign bat_sel = bat_en && (rd_ch == CH_W'(BAT_CH));
    assign g_in[0] = $signed({1'b0, rd_raw});
    assign g_in[1] = comp_q;

    for (genvar gi = 0; gi < 2; gi++) begin : g_gain
        cal_gain #(.IN_W(COMP_W), .OUT_W(CORR_W)) u_gain (
            .x    (g_in[gi]),
            .en   (bat_sel),
            .full (ctrl_in[CTL_DIV_BIT]),
            .y    (g_out[gi])
        );
    end

    assign rd_offset = g_out[1];
    assign rd_corr   = g_out[0] + g_out[1];
endmodule

// File: rtl/adc_offset_cal_chk.sv
// Port-level properties of the calibrator, attached by bind.
module adc_offset_cal_chk #(
    parameter int RES_W  = 10,
    parameter int CTRL_W = 32,
    parameter int NUM_CH = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic                 smp_req,
    input logic                 smp_ack,
    input logic [CTRL_W-1:0]    ctrl_out,
    input logic signed [RES_W:0] comp_value
);
    p_cal_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ctrl_out[4] && ctrl_out[CTRL_W-1:CTRL_W-NUM_CH] == NUM_CH'(1)));

    p_req_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req |-> busy);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req && !smp_ack) |=> smp_req);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_comp_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(comp_value));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !smp_req));

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !smp_req) |=> busy);
endmodule

bind adc_offset_cal adc_offset_cal_chk #(
    .RES_W(RES_W), .CTRL_W(CTRL_W), .NUM_CH(NUM_CH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .smp_req    (smp_req),
    .smp_ack    (smp_ack),
    .ctrl_out   (ctrl_out),
    .comp_value (comp_value)
);

// File: tb/adc_offset_cal_test.sv
`timescale 1ns/1ps
module adc_offset_cal_test;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [19:0]        settle_cycles = '0;
    logic [19:0]        period_cycles = '0;
    logic [31:0]        ctrl_in = '0;
    logic [31:0]        ctrl_out;
    logic               busy, done, smp_req;
    logic               smp_ack = 1'b0;
    logic [9:0]         smp_data = '0;
    logic signed [10:0] comp_value;
    logic               bat_en = 1'b0;
    logic [3:0]         rd_ch = '0;
    logic [9:0]         rd_raw = '0;
    logic signed [13:0] rd_offset, rd_corr;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    adc_offset_cal uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .settle_cycles(settle_cycles), .period_cycles(period_cycles),
        .ctrl_in(ctrl_in), .ctrl_out(ctrl_out), .busy(busy), .done(done),
        .smp_req(smp_req), .smp_ack(smp_ack), .smp_data(smp_data),
        .comp_value(comp_value), .bat_en(bat_en), .rd_ch(rd_ch),
        .rd_raw(rd_raw), .rd_offset(rd_offset), .rd_corr(rd_corr)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cal_word(input logic [31:0] w);
        logic [31:0] r = w;
        r[0] = 1'b1; r[3:1] = 3'b111; r[4] = 1'b1; r[31:16] = 16'h0001;
        return r;
    endfunction

    function automatic int exp_gain(input int v, input bit en, input bit full);
        if (!en) return v;
        if (full) return 3 * v;
        return (3 * v) / 2;
    endfunction

    // Check the corrected-read path for one input pattern (R9, R10).
    task automatic read_check(input int ch, input int raw, input bit be);
        int cv, off, cor;
        bit sel;
        @(negedge clk);
        rd_ch = 4'(ch); rd_raw = 10'(raw); bat_en = be;
        #1;
        cv  = int'(comp_value);
        sel = be && (ch == 7);
        off = exp_gain(cv, sel, ctrl_in[6]);
        cor = exp_gain(raw, sel, ctrl_in[6]) + off;
        if (sel) begin
            chk(int'(rd_offset) == off, "R10 offset", rd_offset, off);
            chk(int'(rd_corr) == cor, "R10 corr", rd_corr, cor);
        end else begin
            chk(int'(rd_offset) == off, "R9 offset", rd_offset, off);
            chk(int'(rd_corr) == cor, "R9 corr", rd_corr, cor);
        end
    endtask

    // One calibration run; mode 0 random, 1 zeros, 2 full scale, 3 midscale.
    task automatic run_cal(input int s, input int p, input int mode, input bit poke);
        logic [31:0] cin;
        int n, g, sum, expv, d, v;
        cin = $urandom;
        @(negedge clk);
        ctrl_in = cin; settle_cycles = 20'(s); period_cycles = 20'(p);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        chk(busy == 1'b1, "R2 busy", busy, 1);
        chk(ctrl_out == exp_cal_word(cin), "R2 ctrl", ctrl_out, exp_cal_word(cin));
        ctrl_in = $urandom;
        while (!smp_req && n < 5000) begin @(negedge clk); n++; end
        chk(n == s + p + 3, "R3 first request", n, s + p + 3);
        sum = 0;
        for (int i = 0; i < 16; i++) begin
            d = $urandom % 3;
            for (int k = 0; k < d; k++) begin
                @(negedge clk);
                chk(smp_req == 1'b1, "R4 hold", smp_req, 1);
            end
            case (mode)
                1: v = 0;
                2: v = 1023;
                3: v = 512;
                default: v = $urandom % 1024;
            endcase
            sum += v;
            smp_ack = 1'b1; smp_data = 10'(v);
            if (poke && i == 5) start = 1'b1;
            @(negedge clk);
            smp_ack = 1'b0; start = 1'b0;
            if (i < 15) begin
                chk(done == 1'b0, "R5 early done", done, 0);
                g = 1;
                while (!smp_req && g < 5000) begin @(negedge clk); g++; end
                chk(g == p + 2, "R4 gap", g, p + 2);
            end else begin
                expv = 512 - (sum >> 4);
                chk(done == 1'b1, "R6 done", done, 1);
                chk(busy == 1'b0, "R6 busy", busy, 0);
                if (mode == 0)
                    chk(int'(comp_value) == expv, "R6 comp", comp_value, expv);
                else
                    chk(int'(comp_value) == expv, "R11 comp", comp_value, expv);
                chk(ctrl_out == cin, "R7 restore", ctrl_out, cin);
            end
        end
        @(negedge clk);
        chk(done == 1'b0, "R6 pulse", done, 0);
        chk(int'(comp_value) == 512 - (sum >> 4), "R6 hold", comp_value, 512 - (sum >> 4));
        if (poke) begin
            repeat (4) @(negedge clk);
            chk(busy == 1'b0 && smp_req == 1'b0, "R8 no rerun", busy, 0);
        end
    endtask

    initial begin : wd
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(smp_req == 1'b0, "R1 req", smp_req, 0);
        chk(comp_value == 11'sd0, "R1 comp", comp_value, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cal(0, 0, 1, 1'b0);
        read_check(3, 100, 1'b0);
        run_cal(7, 3, 2, 1'b0);
        read_check(7, 1023, 1'b1);
        read_check(7, 1, 1'b1);
        run_cal(2, 1, 3, 1'b0);
        read_check(0, 512, 1'b1);
        for (int r = 0; r < 5; r++) begin
            run_cal($urandom % 40, $urandom % 12, 0, r == 2);
            for (int q = 0; q < 4; q++)
                read_check((q == 0) ? 7 : $urandom % 16, $urandom % 1024, $urandom % 2);
        end
        run_cal(1, 2, 0, 1'b1);
        read_check(7, 5, 1'b1);
        read_check(7, 600, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule